// File: doc/BRIEF.md
# Auto-Trigger Acquisition Sequencer

This block controls when a multi-channel analog front-end freezes its samples. Each of 36 discriminator outputs, and one external force input used for pedestal runs, can start a capture for the whole chip. Every capture pulses a hold line for the current cell of a shared cyclic memory column of 5 cells. It also stores the current 24-bit bunch-crossing number for that cell and moves the shared write pointer on by one.

Capture stops when all cells are used. A readout request then sends the stored crossing numbers out one per cycle, in the order they were written. An end pulse follows, and the column is freed for the next acquisition. The analog storage, shaping and conversion sit outside this block. It owns only the pointer, the hold strobes, the crossing counter and the timestamp store.

Top module: `acq_trig_sequencer`

## Requirements
- R1: After reset `wr_ptr_o`, `mem_full_o`, `hold_o`, `rd_valid_o`, `rd_end_o` and `bx_count_o` are all zero.
- R2: `bx_count_o` increments by one on every clock with `bx_tick` high and wraps modulo 2^24. `acq_start` clears it to zero and takes priority over `bx_tick`.
- R3: A rising edge on any bit of `chan_trig` is synchronised through two flops. Three clocks after the input changes, `hold_o` shows a one-cycle pulse on bit `wr_ptr_o` (cell 0 is bit 0), and `wr_ptr_o` increments by one in the same cycle.
- R4: A rising edge on `force_trig` produces exactly the same capture as a channel trigger.
- R5: Captures are edge-triggered. A trigger input held high yields one capture, and a new capture needs the combined trigger to go low and then high again.
- R6: At most one capture is taken per bunch-crossing period. After a capture, further trigger edges are ignored until a clock with `bx_tick` high has occurred. A capture in the same clock as `bx_tick` belongs to the ending period and leaves the next period free.
- R7: Each capture stores the value `bx_count_o` held just before the capturing clock edge.
- R8: After 5 captures `mem_full_o` is high and `wr_ptr_o` equals 5. Further triggers leave `hold_o` low and `wr_ptr_o` unchanged.
- R9: In acquisition, a `readout_req` pulse makes the stored values appear on `rd_bxid_o`, one per clock, in write order, each with `rd_valid_o` high. The first appears on the second clock after the request. A one-cycle `rd_end_o` follows the last one, and in that cycle `wr_ptr_o` is 0 and `mem_full_o` is 0.
- R10: A readout with no stored captures gives only the `rd_end_o` pulse, one clock after the request is sampled, with no `rd_valid_o`.
- R11: Trigger edges that arrive during a readout cause no capture, either then or after the readout ends.
- R12: `acq_start` clears `wr_ptr_o` and `mem_full_o` and aborts a running readout, so no `rd_valid_o` or `rd_end_o` follows it.
- R13: `readout_req` wins over a capture sampled in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_start | input | 1 | Start-of-acquisition pulse |
| bx_tick | input | 1 | One-clock pulse per bunch crossing |
| chan_trig | input | 36 | Per-channel discriminator outputs (asynchronous) |
| force_trig | input | 1 | External forced trigger (asynchronous) |
| readout_req | input | 1 | Start draining stored crossing numbers |
| hold_o | output | 5 | One-hot hold strobe per memory cell |
| wr_ptr_o | output | 3 | Number of filled cells (next cell to write) |
| mem_full_o | output | 1 | All cells filled |
| bx_count_o | output | 24 | Current bunch-crossing number |
| rd_valid_o | output | 1 | `rd_bxid_o` carries a stored value |
| rd_bxid_o | output | 24 | Stored crossing number being read out |
| rd_end_o | output | 1 | One-cycle end-of-data pulse |

## Verification
A capture and a bunch-crossing tick can land on the same clock edge. This decides both which crossing number is stored and whether the next period may capture again. The bench provokes it by raising `bx_tick` exactly on the clock that registers a synchronised trigger edge. It expects the pre-tick count as the stored value and expects a second trigger, fired with no further tick, to be accepted. A readout request is also placed on the same clock as a pending capture. There the bench expects no hold pulse and a readout of the earlier entries only.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic {
    ST_ACQ  = 1'b0,
    ST_READ = 1'b1
  } seq_state_t;

  function automatic int unsigned cnt_width(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/acq_trig_front.sv
module acq_trig_front #(
  parameter int unsigned NCH = 36
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] chan_trig,
  input  logic           force_trig,
  output logic           trig_edge
);
  logic [NCH-1:0] ch_s1, ch_s2;
  logic           frc_s1, frc_s2;
  logic           any_trig, any_prev;

  // two-flop synchroniser per channel
  for (genvar i = 0; i < NCH; i++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) begin
        ch_s1[i] <= 1'b0;
        ch_s2[i] <= 1'b0;
      end else begin
        ch_s1[i] <= chan_trig[i];
        ch_s2[i] <= ch_s1[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frc_s1   <= 1'b0;
      frc_s2   <= 1'b0;
      any_prev <= 1'b0;
    end else begin
      frc_s1   <= force_trig;
      frc_s2   <= frc_s1;
      any_prev <= any_trig;
    end
  end

  assign any_trig  = (|ch_s2) | frc_s2;
  assign trig_edge = any_trig & ~any_prev;

  AST_EDGE_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
    trig_edge |=> !trig_edge); // R5
endmodule

// File: rtl/acq_bx_counter.sv
module acq_bx_counter #(
  parameter int unsigned BX_W = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            tick,
  output logic [BX_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (tick)  count <= count + 1'b1;
  end

  AST_BX_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr) |=> count == BX_W'($past(count) + 1'b1)); // R2
  AST_BX_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> count == '0); // R2
  AST_BX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr) |=> $stable(count)); // R2
endmodule

// File: rtl/acq_ts_store.sv
module acq_ts_store #(
  parameter int unsigned DEPTH  = 5,
  parameter int unsigned BX_W   = 24,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [BX_W-1:0]   wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [BX_W-1:0]   rdata
);
  logic [BX_W-1:0] mem [DEPTH];

  // simple dual-port, registered read: maps onto block or distributed RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/acq_seq_ctrl.sv
module acq_seq_ctrl
  import acq_pkg::*;
#(
  parameter int unsigned DEPTH  = 5,
  parameter int unsigned CNT_W  = $clog2(DEPTH + 1),
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acq_start,
  input  logic              bx_tick,
  input  logic              trig_edge,
  input  logic              readout_req,
  output logic [DEPTH-1:0]  hold_o,
  output logic [CNT_W-1:0]  wr_ptr_o,
  output logic              full_o,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic              rd_valid_o,
  output logic              rd_end_o
);
  localparam logic [CNT_W-1:0] LAST_CELL = CNT_W'(DEPTH - 1);

  seq_state_t       state_q;
  logic [CNT_W-1:0] wr_ptr_q, rd_ptr_q;
  logic             full_q, taken_q;
  logic             capture;
  logic             rd_more;
  logic [DEPTH-1:0] hold_d, hold_q;
  logic             valid_q, end_q;

  assign capture = (state_q == ST_ACQ) && !readout_req && trig_edge
                   && !taken_q && !full_q;
  assign rd_more = (state_q == ST_READ) && (rd_ptr_q < wr_ptr_q);

  for (genvar c = 0; c < DEPTH; c++) begin : g_hold
    assign hold_d[c] = capture && (wr_ptr_q == CNT_W'(c));
  end

  assign mem_we    = capture;
  assign mem_waddr = wr_ptr_q[ADDR_W-1:0];
  assign mem_re    = rd_more;
  assign mem_raddr = rd_ptr_q[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || acq_start) begin
      state_q  <= ST_ACQ;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      full_q   <= 1'b0;
      taken_q  <= 1'b0;
      hold_q   <= '0;
      valid_q  <= 1'b0;
      end_q    <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      valid_q <= 1'b0;
      end_q   <= 1'b0;
      if (bx_tick)      taken_q <= 1'b0;
      else if (capture) taken_q <= 1'b1;
      unique case (state_q)
        ST_ACQ: begin
          if (readout_req) begin
            state_q  <= ST_READ;
            rd_ptr_q <= '0;
          end else if (capture) begin
            wr_ptr_q <= wr_ptr_q + 1'b1;
            full_q   <= (wr_ptr_q == LAST_CELL);
          end
        end
        ST_READ: begin
          if (rd_more) begin
            valid_q  <= 1'b1;
            rd_ptr_q <= rd_ptr_q + 1'b1;
          end else begin
            end_q    <= 1'b1;
            state_q  <= ST_ACQ;
            wr_ptr_q <= '0;
            full_q   <= 1'b0;
          end
        end
        default: state_q <= ST_ACQ;
      endcase
    end
  end

  assign hold_o     = hold_q;
  assign wr_ptr_o   = wr_ptr_q;
  assign full_o     = full_q;
  assign rd_valid_o = valid_q;
  assign rd_end_o   = end_q;

  AST_HOLD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hold_q)); // R3
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (capture && !acq_start) |=> wr_ptr_q == CNT_W'($past(wr_ptr_q) + 1'b1)); // R3
  AST_ONE_PER_BX: assert property (@(posedge clk) disable iff (rst)
    (taken_q && !acq_start) |=> hold_q == '0); // R6
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (full_q && !acq_start) |=> hold_q == '0); // R8
  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (rst)
    wr_ptr_q <= CNT_W'(DEPTH)); // R8
  AST_VALID_END_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(valid_q && end_q)); // R9
  AST_END_FREES: assert property (@(posedge clk) disable iff (rst)
    end_q |-> (wr_ptr_q == '0 && !full_q)); // R9
  AST_READ_NO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_READ) |=> hold_q == '0); // R11
  AST_START_ABORT: assert property (@(posedge clk) disable iff (rst)
    acq_start |=> (!valid_q && !end_q && wr_ptr_q == '0)); // R12
endmodule

// File: rtl/acq_trig_sequencer.sv
module acq_trig_sequencer #(
  parameter int unsigned NCH   = 36,
  parameter int unsigned DEPTH = 5,
  parameter int unsigned BX_W  = 24
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         acq_start,
  input  logic                         bx_tick,
  input  logic [NCH-1:0]               chan_trig,
  input  logic                         force_trig,
  input  logic                         readout_req,
  output logic [DEPTH-1:0]             hold_o,
  output logic [$clog2(DEPTH+1)-1:0]   wr_ptr_o,
  output logic                         mem_full_o,
  output logic [BX_W-1:0]              bx_count_o,
  output logic                         rd_valid_o,
  output logic [BX_W-1:0]              rd_bxid_o,
  output logic                         rd_end_o
);
  localparam int unsigned CNT_W  = acq_pkg::cnt_width(DEPTH);
  localparam int unsigned ADDR_W = $clog2(DEPTH);

  logic              trig_edge;
  logic              mem_we, mem_re;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [BX_W-1:0]   bx_count;

  acq_trig_front #(.NCH(NCH)) u_front (
    .clk        (clk),
    .rst        (rst),
    .chan_trig  (chan_trig),
    .force_trig (force_trig),
    .trig_edge  (trig_edge)
  );

  acq_bx_counter #(.BX_W(BX_W)) u_bx (
    .clk   (clk),
    .rst   (rst),
    .clr   (acq_start),
    .tick  (bx_tick),
    .count (bx_count)
  );

  acq_seq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .acq_start   (acq_start),
    .bx_tick     (bx_tick),
    .trig_edge   (trig_edge),
    .readout_req (readout_req),
    .hold_o      (hold_o),
    .wr_ptr_o    (wr_ptr_o),
    .full_o      (mem_full_o),
    .mem_we      (mem_we),
    .mem_waddr   (mem_waddr),
    .mem_re      (mem_re),
    .mem_raddr   (mem_raddr),
    .rd_valid_o  (rd_valid_o),
    .rd_end_o    (rd_end_o)
  );

  acq_ts_store #(.DEPTH(DEPTH), .BX_W(BX_W), .ADDR_W(ADDR_W)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (bx_count),
    .re    (mem_re),
    .raddr (mem_raddr),
    .rdata (rd_bxid_o)
  );

  assign bx_count_o = bx_count;
endmodule

// File: tb/tb_acq_trig_sequencer.sv
`timescale 1ns/1ps
module tb_acq_trig_sequencer;
  localparam int NCH = 36, DEPTH = 5, BX_W = 24;

  logic clk = 1'b0, rst = 1'b1, acq_start = 1'b0, bx_tick = 1'b0;
  logic [NCH-1:0] chan_trig = '0;
  logic force_trig = 1'b0, readout_req = 1'b0;
  logic [DEPTH-1:0] hold_o;
  logic [2:0] wr_ptr_o;
  logic mem_full_o, rd_valid_o, rd_end_o;
  logic [BX_W-1:0] bx_count_o, rd_bxid_o;

  int total = 0, bad = 0;
  int unsigned bx_m = 0;
  int unsigned ts_m [DEPTH];
  int n_m = 0;
  bit taken_m = 0;

  always #4 clk = ~clk;

  acq_trig_sequencer dut (.*);

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [DEPTH-1:0] exp_hold(input bit cap, input int ptr);
    return cap ? (DEPTH'(1) << ptr) : '0;
  endfunction

  task automatic step(); @(negedge clk); endtask

  task automatic tick();
    bx_tick = 1'b1; step(); bx_tick = 1'b0;
    bx_m = (bx_m + 1) & 32'hFF_FFFF; taken_m = 0;
  endtask

  // drive one trigger edge; tick_on_cap puts bx_tick on the capturing edge
  task automatic fire(input int ch, input bit use_force, input bit tick_on_cap, input string tag);
    bit cap;
    if (use_force) force_trig = 1'b1; else chan_trig[ch] = 1'b1;
    step(); step();
    if (tick_on_cap) bx_tick = 1'b1;
    step();
    bx_tick = 1'b0;
    cap = (n_m < DEPTH) && !taken_m;
    check(hold_o == exp_hold(cap, n_m), tag, hold_o, exp_hold(cap, n_m));
    if (cap) begin ts_m[n_m] = bx_m; n_m++; taken_m = 1; end
    if (tick_on_cap) begin bx_m = (bx_m + 1) & 32'hFF_FFFF; taken_m = 0; end
    check(wr_ptr_o == 3'(n_m), "R3 ptr", wr_ptr_o, n_m);
    check(mem_full_o == (n_m == DEPTH), "R8 full", mem_full_o, n_m == DEPTH);
    if (use_force) force_trig = 1'b0; else chan_trig[ch] = 1'b0;
    step();
    check(hold_o == '0, "R3 one-cycle hold", hold_o, 0);
    step(); step();
  endtask

  task automatic readout(input string tag);
    readout_req = 1'b1; step(); readout_req = 1'b0;
    for (int k = 0; k < n_m; k++) begin
      step();
      check(rd_valid_o && !rd_end_o, {tag, " valid"}, rd_valid_o, 1);
      check(rd_bxid_o == BX_W'(ts_m[k]), "R7 stamp order", rd_bxid_o, ts_m[k]);
    end
    step();
    check(rd_end_o && !rd_valid_o, {tag, " end"}, rd_end_o, 1);
    check(wr_ptr_o == 0 && !mem_full_o, "R9 freed", wr_ptr_o, 0);
    step();
    check(!rd_end_o && !rd_valid_o, "R9 end one cycle", rd_end_o, 0);
    n_m = 0;
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    step(); step(); rst = 1'b0; step();
    // R1
    check(wr_ptr_o == 0 && !mem_full_o && hold_o == 0, "R1 ptr/full/hold", wr_ptr_o, 0);
    check(!rd_valid_o && !rd_end_o && bx_count_o == 0, "R1 rd/bx", bx_count_o, 0);
    // R2 increments and clear priority
    repeat (7) tick();
    check(bx_count_o == BX_W'(bx_m), "R2 count", bx_count_o, bx_m);
    acq_start = 1'b1; bx_tick = 1'b1; step(); acq_start = 1'b0; bx_tick = 1'b0;
    bx_m = 0; taken_m = 0;
    check(bx_count_o == 0, "R2 clear wins", bx_count_o, 0);
    // R10 empty readout
    readout("R10");
    // R3 channel, R4 force, R6 one per period
    tick(); tick();
    fire(35, 0, 0, "R3 channel hold");
    fire(0, 0, 0, "R6 same period blocked");
    tick();
    fire(0, 1, 0, "R4 force hold");
    // R6 capture on tick edge: old stamp, next period open
    tick();
    fire(17, 0, 1, "R6 capture on tick");
    fire(3, 0, 0, "R6 next period open");
    // R8 full, further triggers ignored
    tick();
    fire(9, 1, 0, "R8 fifth capture");
    tick();
    fire(12, 0, 0, "R8 ignored when full");
    check(bx_count_o == BX_W'(bx_m), "R7 count model", bx_count_o, bx_m);
    readout("R9");
    // R5 held level gives one capture
    tick();
    chan_trig[5] = 1'b1; step(); step(); step();
    check(hold_o == 5'b00001, "R5 first capture", hold_o, 1);
    ts_m[0] = bx_m; n_m = 1; taken_m = 1;
    tick(); tick();
    repeat (4) begin step(); check(hold_o == 0 && wr_ptr_o == 1, "R5 level no recapture", wr_ptr_o, 1); end
    chan_trig[5] = 1'b0; step(); step(); step();
    // R11 trigger during readout
    tick();
    fire(20, 0, 0, "R11 fill");
    readout_req = 1'b1; step(); readout_req = 1'b0;
    force_trig = 1'b1;
    step(); check(rd_bxid_o == BX_W'(ts_m[0]) && rd_valid_o, "R9 first", rd_bxid_o, ts_m[0]);
    step(); check(rd_bxid_o == BX_W'(ts_m[1]) && rd_valid_o, "R9 second", rd_bxid_o, ts_m[1]);
    step(); check(rd_end_o, "R9 end", rd_end_o, 1);
    n_m = 0;
    tick();
    repeat (5) begin step(); check(hold_o == 0 && wr_ptr_o == 0, "R11 no late capture", wr_ptr_o, 0); end
    force_trig = 1'b0; step(); step(); step();
    // R13 readout request on the capture edge
    tick();
    fire(1, 0, 0, "R13 fill");
    tick();
    chan_trig[2] = 1'b1; step(); step();
    readout_req = 1'b1; step(); readout_req = 1'b0;
    check(hold_o == 0, "R13 request wins", hold_o, 0);
    step(); check(rd_valid_o && rd_bxid_o == BX_W'(ts_m[0]), "R13 old entry", rd_bxid_o, ts_m[0]);
    step(); check(rd_end_o, "R13 end", rd_end_o, 1);
    n_m = 0;
    chan_trig[2] = 1'b0; step(); step(); step();
    // R12 abort readout
    tick();
    fire(7, 0, 0, "R12 fill a"); tick();
    fire(8, 0, 0, "R12 fill b");
    readout_req = 1'b1; step(); readout_req = 1'b0;
    acq_start = 1'b1; step(); acq_start = 1'b0;
    bx_m = 0; n_m = 0; taken_m = 0;
    check(wr_ptr_o == 0 && !mem_full_o && bx_count_o == 0, "R12 cleared", wr_ptr_o, 0);
    repeat (4) begin step(); check(!rd_valid_o && !rd_end_o, "R12 no readout", rd_valid_o, 0); end
    // random mix
    for (int it = 0; it < 120; it++) begin
      int op = $urandom_range(0, 9);
      if (op <= 5) begin
        if ($urandom_range(0, 1)) tick();
        fire($urandom_range(0, NCH - 1), $urandom_range(0, 3) == 0, 0, "R3 random");
      end else if (op == 6) readout("R9 random");
      else if (op == 7) repeat ($urandom_range(1, 4)) tick();
      else step();
      check(bx_count_o == BX_W'(bx_m), "R2 random count", bx_count_o, bx_m);
    end
    readout("R9 final");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule